// File: doc/BRIEF.md
# SPI Master Channel Transfer Engine

This block is a single channel slice of a multi-channel SPI master. It keeps the channel's configuration word, a three-flag status word, a channel enable bit and the transmit and receive data words. Software reaches it through simple per-channel strobes: configuration write, enable write, transmit-data write and receive-data read. Each transmit write, receive read or enable rising edge asks for a transfer attempt. The engine then decides from the transfer mode and the current flags whether a serial exchange may run.

An exchange shifts a word of programmable length out MSB-first on MOSI. It samples MISO into the receive word and, on completion, sets the end-of-transfer, transmit-empty and (mode permitting) receive-full flags. Two DMA request lines follow the flags, the mode and the per-direction request enables. Two one-cycle pulses tell a shared interrupt block which flag conditions hold after each resolved attempt. A global single-channel input can suppress the serial activity while still letting the flags advance.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 3'b010 (bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer), the enable, transmit and receive words read 0, and both DMA requests are low.
- R2: A configuration write stores only bits 22:0 of the written value, visible the cycle after the strobe.
- R3: An enable write of 1 while the channel is off sets enable and requests an attempt. Any other enable write stores the written bit. While the channel is off, attempts are discarded and no serial activity occurs.
- R4: A transmit write stores the data, clears transmit-empty and requests an attempt. A completed transfer clears the transmit word and sets end-of-transfer and transmit-empty, which stays set until reset.
- R5: An exchange sends (configuration bits 11:7)+1 bits MSB-first. SCLK runs at half the module clock, with MISO sampled on each SCLK rise. The received bits, first bit most significant, form the new receive word.
- R6: In receive-only mode (bits 13:12 = 1), a set transmit-empty does not block an attempt, and completion sets receive-full.
- R7: In transmit-only mode (bits 13:12 = 2), receive-full neither blocks an attempt nor is set on completion.
- R8: An attempt is blocked when receive-full is set, the mode is not transmit-only and configuration bit 19 is clear, or when transmit-empty is set and the mode is not receive-only. With bit 19 set, a full receive word does not block.
- R9: A receive read clears receive-full and requests an attempt.
- R10: With the global single-channel input high and configuration bit 20 clear, an unblocked attempt completes at once with no SCLK activity and an unchanged receive word, while the flags and transmit word update as for a completed transfer.
- R11: The transmit DMA request is high exactly when enabled, configuration bit 14 set, transmit-empty set and mode not receive-only. The receive DMA request is high exactly when enabled, bit 15 set, receive-full set and mode not transmit-only.
- R12: The cycle after an attempt resolves (blocked or completed), the receive pulse fires if receive-full is set, the mode is not transmit-only and bit 19 is clear. The transmit pulse fires if transmit-empty is set and the mode is not receive-only.
- R13: An attempt requested while a word is shifting is held and resolved after that word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_single_i | input | 1 | Global single-channel mode bit |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable write data |
| tx_wr_i | input | 1 | Transmit word write strobe |
| tx_wdata_i | input | DATA_W | Transmit word write data |
| rx_rd_i | input | 1 | Receive word read strobe |
| miso_i | input | 1 | Serial data from the slave |
| cfg_o | output | CFG_W | Configuration word |
| status_o | output | 3 | Status flags |
| enable_o | output | 1 | Channel enable |
| tx_o | output | DATA_W | Transmit word |
| rx_o | output | DATA_W | Receive word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |
| irq_rxf_o | output | 1 | Receive-full interrupt set pulse |
| irq_txe_o | output | 1 | Transmit-empty interrupt set pulse |

## Verification
The bench builds the engine with its defaults: a 32-bit data word, a 5-bit length field and a 23-bit configuration word. With a 5-bit length field and a 32-bit word, both an 8-bit exchange and a full 32-bit exchange can be run. A 23-bit configuration shows the masking of a written all-ones word. The reference model tracks the pending-attempt latch and the word countdown, so held attempts during a busy word, blocking by each flag in each mode, and the no-shift completion path are all compared cycle by cycle.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
   typedef enum logic [1:0] {
      XM_DUPLEX  = 2'd0,
      XM_RX_ONLY = 2'd1,
      XM_TX_ONLY = 2'd2,
      XM_RSVD    = 2'd3
   } xfer_mode_e;

   // status flag positions
   localparam int ST_RXF = 0;
   localparam int ST_TXE = 1;
   localparam int ST_EOT = 2;
   localparam int ST_W   = 3;

   // configuration field positions
   localparam int CFG_WL_LSB   = 7;
   localparam int CFG_MODE_LSB = 12;
   localparam int CFG_TXDMA    = 14;
   localparam int CFG_RXDMA    = 15;
   localparam int CFG_RXBYP    = 19;
   localparam int CFG_FORCE    = 20;
   localparam logic [31:0] CFG_RST = 32'h0006_0000;
endpackage

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [DATA_W-1:0] tx_word_i,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_word_o
);
   localparam logic [LEN_W-1:0] SH_MAX = LEN_W'(DATA_W - 1);

   generate
      if (DATA_W != (1 << LEN_W)) begin : g_bad_len
         $error("spi_chan_shifter: DATA_W must equal 2**LEN_W");
      end
   endgenerate

   logic              active_q, phase_q, done_q, sclk_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [DATA_W-1:0] tsh_q, rsh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         done_q   <= 1'b0;
         sclk_q   <= 1'b0;
         cnt_q    <= '0;
         tsh_q    <= '0;
         rsh_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            sclk_q   <= 1'b0;
            cnt_q    <= len_i;
            tsh_q    <= tx_word_i << (SH_MAX - len_i);
            rsh_q    <= '0;
         end else if (active_q) begin
            if (!phase_q) begin
               sclk_q  <= 1'b1;
               rsh_q   <= {rsh_q[DATA_W-2:0], miso_i};
               phase_q <= 1'b1;
            end else begin
               sclk_q  <= 1'b0;
               tsh_q   <= tsh_q << 1;
               phase_q <= 1'b0;
               if (cnt_q == '0) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
      end
   end

   assign sclk_o    = sclk_q;
   assign mosi_o    = active_q & tsh_q[DATA_W-1];
   assign busy_o    = active_q | done_q;
   assign done_o    = done_q;
   assign rx_word_o = rsh_q;
endmodule

// File: rtl/spi_chan_dreq.sv
module spi_chan_dreq
   import spi_chan_pkg::*;
(
   input  logic             en_i,
   input  logic [1:0]       dma_en_i,
   input  logic [ST_W-1:0]  status_i,
   input  xfer_mode_e       mode_i,
   output logic [1:0]       dreq_o
);
   // index 0: transmit direction, index 1: receive direction
   generate
      for (genvar d = 0; d < 2; d++) begin : g_dir
         localparam int         FLAG = (d == 0) ? ST_TXE : ST_RXF;
         localparam xfer_mode_e SKIP = (d == 0) ? XM_RX_ONLY : XM_TX_ONLY;
         assign dreq_o[d] = en_i & dma_en_i[d] & status_i[FLAG] & (mode_i != SKIP);
      end
   endgenerate
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
   import spi_chan_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5,
   parameter int CFG_W  = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_single_i,
   input  logic              cfg_wr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic              en_wr_i,
   input  logic              en_wdata_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_wdata_i,
   input  logic              rx_rd_i,
   input  logic              sh_busy_i,
   input  logic              sh_done_i,
   input  logic [DATA_W-1:0] sh_rx_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic [ST_W-1:0]   status_o,
   output logic              enable_o,
   output logic [DATA_W-1:0] tx_o,
   output logic [DATA_W-1:0] rx_o,
   output logic              sh_start_o,
   output logic [LEN_W-1:0]  sh_len_o,
   output xfer_mode_e        mode_o,
   output logic              irq_rxf_o,
   output logic              irq_txe_o
);
   localparam logic [CFG_W-1:0] CFG_INIT = CFG_RST[CFG_W-1:0];

   logic [CFG_W-1:0]  cfg_q, cfg_n;
   logic [ST_W-1:0]   st_q, st_n;
   logic              en_q, en_n, try_q, try_n;
   logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n;
   logic              prx_q, ptx_q, prx_n, ptx_n;
   logic              resolve, start, blocked, shift_ok;
   xfer_mode_e        mode;

   assign mode     = xfer_mode_e'(cfg_q[CFG_MODE_LSB +: 2]);
   assign blocked  = (st_q[ST_RXF] && mode != XM_TX_ONLY && !cfg_q[CFG_RXBYP]) ||
                     (st_q[ST_TXE] && mode != XM_RX_ONLY);
   assign shift_ok = !glb_single_i || cfg_q[CFG_FORCE];

   always_comb begin
      cfg_n   = cfg_q;
      st_n    = st_q;
      en_n    = en_q;
      tx_n    = tx_q;
      rx_n    = rx_q;
      try_n   = try_q;
      resolve = 1'b0;
      start   = 1'b0;
      // attempt resolution and word completion
      if (sh_done_i) begin
         tx_n         = '0;
         st_n[ST_EOT] = 1'b1;
         st_n[ST_TXE] = 1'b1;
         if (mode != XM_TX_ONLY) st_n[ST_RXF] = 1'b1;
         rx_n         = sh_rx_i;
         resolve      = 1'b1;
      end else if (try_q && en_q && !sh_busy_i) begin
         try_n = 1'b0;
         if (blocked) begin
            resolve = 1'b1;
         end else if (shift_ok) begin
            start = 1'b1;
         end else begin
            tx_n         = '0;
            st_n[ST_EOT] = 1'b1;
            st_n[ST_TXE] = 1'b1;
            if (mode != XM_TX_ONLY) st_n[ST_RXF] = 1'b1;
            resolve      = 1'b1;
         end
      end else if (try_q && !en_q) begin
         try_n = 1'b0;
      end
      // register strobes
      if (cfg_wr_i) cfg_n = cfg_wdata_i[CFG_W-1:0];
      if (tx_wr_i) begin
         tx_n         = tx_wdata_i;
         st_n[ST_TXE] = 1'b0;
         try_n        = 1'b1;
      end
      if (rx_rd_i) begin
         st_n[ST_RXF] = 1'b0;
         try_n        = 1'b1;
      end
      if (en_wr_i) begin
         if (en_wdata_i && !en_q) begin
            en_n  = 1'b1;
            try_n = 1'b1;
         end else begin
            en_n = en_wdata_i;
         end
      end
      prx_n = resolve && st_n[ST_RXF] && mode != XM_TX_ONLY && !cfg_q[CFG_RXBYP];
      ptx_n = resolve && st_n[ST_TXE] && mode != XM_RX_ONLY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= CFG_INIT;
         st_q  <= ST_W'(1 << ST_TXE);
         en_q  <= 1'b0;
         try_q <= 1'b0;
         tx_q  <= '0;
         rx_q  <= '0;
         prx_q <= 1'b0;
         ptx_q <= 1'b0;
      end else begin
         cfg_q <= cfg_n;
         st_q  <= st_n;
         en_q  <= en_n;
         try_q <= try_n;
         tx_q  <= tx_n;
         rx_q  <= rx_n;
         prx_q <= prx_n;
         ptx_q <= ptx_n;
      end
   end

   assign cfg_o      = cfg_q;
   assign status_o   = st_q;
   assign enable_o   = en_q;
   assign tx_o       = tx_q;
   assign rx_o       = rx_q;
   assign sh_start_o = start;
   assign sh_len_o   = cfg_q[CFG_WL_LSB +: LEN_W];
   assign mode_o     = mode;
   assign irq_rxf_o  = prx_q;
   assign irq_txe_o  = ptx_q;
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
   import spi_chan_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5,
   parameter int CFG_W  = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_single_i,
   input  logic              cfg_wr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic              en_wr_i,
   input  logic              en_wdata_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_wdata_i,
   input  logic              rx_rd_i,
   input  logic              miso_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic [2:0]        status_o,
   output logic              enable_o,
   output logic [DATA_W-1:0] tx_o,
   output logic [DATA_W-1:0] rx_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              tx_dreq_o,
   output logic              rx_dreq_o,
   output logic              irq_rxf_o,
   output logic              irq_txe_o
);
   generate
      if (CFG_W <= CFG_FORCE || CFG_W > DATA_W) begin : g_bad_cfg
         $error("spi_chan_engine: CFG_W out of range");
      end
      if (CFG_WL_LSB + LEN_W > CFG_MODE_LSB) begin : g_bad_wl
         $error("spi_chan_engine: length field overlaps mode field");
      end
   endgenerate

   logic              sh_busy, sh_done, sh_start;
   logic [DATA_W-1:0] sh_rx;
   logic [LEN_W-1:0]  sh_len;
   logic [1:0]        dreq;
   xfer_mode_e        mode;

   spi_chan_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .glb_single_i (glb_single_i),
      .cfg_wr_i     (cfg_wr_i),
      .cfg_wdata_i  (cfg_wdata_i),
      .en_wr_i      (en_wr_i),
      .en_wdata_i   (en_wdata_i),
      .tx_wr_i      (tx_wr_i),
      .tx_wdata_i   (tx_wdata_i),
      .rx_rd_i      (rx_rd_i),
      .sh_busy_i    (sh_busy),
      .sh_done_i    (sh_done),
      .sh_rx_i      (sh_rx),
      .cfg_o        (cfg_o),
      .status_o     (status_o),
      .enable_o     (enable_o),
      .tx_o         (tx_o),
      .rx_o         (rx_o),
      .sh_start_o   (sh_start),
      .sh_len_o     (sh_len),
      .mode_o       (mode),
      .irq_rxf_o    (irq_rxf_o),
      .irq_txe_o    (irq_txe_o)
   );

   spi_chan_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (sh_start),
      .len_i     (sh_len),
      .tx_word_i (tx_o),
      .miso_i    (miso_i),
      .sclk_o    (sclk_o),
      .mosi_o    (mosi_o),
      .busy_o    (sh_busy),
      .done_o    (sh_done),
      .rx_word_o (sh_rx)
   );

   spi_chan_dreq i_dreq (
      .en_i     (enable_o),
      .dma_en_i ({cfg_o[CFG_RXDMA], cfg_o[CFG_TXDMA]}),
      .status_i (status_o),
      .mode_i   (mode),
      .dreq_o   (dreq)
   );

   assign tx_dreq_o = dreq[0];
   assign rx_dreq_o = dreq[1];
endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk #(
   parameter int DATA_W = 32,
   parameter int CFG_W  = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_i,
   input logic [DATA_W-1:0] cfg_wdata_i,
   input logic              tx_wr_i,
   input logic              rx_rd_i,
   input logic [CFG_W-1:0]  cfg_o,
   input logic [2:0]        status_o,
   input logic              enable_o,
   input logic              sclk_o,
   input logic              tx_dreq_o,
   input logic              rx_dreq_o
);
   p_cfg_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_i |=> cfg_o == CFG_W'($past(cfg_wdata_i)));

   p_txe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_i |=> !status_o[1]);

   p_eot_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[2] |=> status_o[2]);

   p_sclk_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |=> !sclk_o);

   p_rxf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd_i |=> !status_o[0]);

   p_txdreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dreq_o |-> (enable_o && status_o[1]));

   p_rxdreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dreq_o |-> (enable_o && status_o[0]));
endmodule

bind spi_chan_engine spi_chan_engine_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_i    (cfg_wr_i),
   .cfg_wdata_i (cfg_wdata_i),
   .tx_wr_i     (tx_wr_i),
   .rx_rd_i     (rx_rd_i),
   .cfg_o       (cfg_o),
   .status_o    (status_o),
   .enable_o    (enable_o),
   .sclk_o      (sclk_o),
   .tx_dreq_o   (tx_dreq_o),
   .rx_dreq_o   (rx_dreq_o)
);

// File: tb/test_spi_chan_engine.sv
`timescale 1ns/1ps
module test_spi_chan_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glb_single = 1'b0;
   logic        cfg_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
   logic [31:0] cfg_wdata = '0, tx_wdata = '0;
   logic        miso = 1'b0;
   logic [22:0] cfg_o;
   logic [2:0]  status_o;
   logic        enable_o, sclk_o, mosi_o, tx_dreq_o, rx_dreq_o, irq_rxf_o, irq_txe_o;
   logic [31:0] tx_o, rx_o;

   always #2 clk = ~clk;

   spi_chan_engine i_spi_chan_engine (
      .clk(clk), .rst_n(rst_n), .glb_single_i(glb_single),
      .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
      .en_wr_i(en_wr), .en_wdata_i(en_wdata),
      .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .rx_rd_i(rx_rd), .miso_i(miso),
      .cfg_o(cfg_o), .status_o(status_o), .enable_o(enable_o), .tx_o(tx_o), .rx_o(rx_o),
      .sclk_o(sclk_o), .mosi_o(mosi_o), .tx_dreq_o(tx_dreq_o), .rx_dreq_o(rx_dreq_o),
      .irq_rxf_o(irq_rxf_o), .irq_txe_o(irq_txe_o)
   );

   int vectors = 0, fails = 0, cyc = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [22:0] m_cfg;
   logic [2:0]  m_st;
   logic        m_en, m_try, m_prx, m_ptx;
   logic [31:0] m_tx, m_rx, m_exp_rx;
   int          m_cnt;
   logic [31:0] slave_word = '0;
   int          cur_len = 8;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 23'h060000; m_st = 3'b010; m_en = 0; m_try = 0;
         m_tx = 0; m_rx = 0; m_cnt = 0; m_prx = 0; m_ptx = 0; m_exp_rx = 0;
      end else begin
         logic [22:0] n_cfg; logic [2:0] n_st; logic n_en, n_try;
         logic [31:0] n_tx, n_rx;
         int len, mode; bit resolve, start, blk;
         n_cfg = m_cfg; n_st = m_st; n_en = m_en; n_try = m_try; n_tx = m_tx; n_rx = m_rx;
         len = int'(m_cfg[11:7]) + 1;
         mode = int'(m_cfg[13:12]);
         resolve = 0; start = 0;
         if (m_cnt == 1) begin
            n_tx = 0; n_st = n_st | 3'b110; if (mode != 2) n_st[0] = 1;
            n_rx = m_exp_rx; resolve = 1;
         end else if (m_try && m_en && m_cnt == 0) begin
            n_try = 0;
            blk = (m_st[0] && mode != 2 && !m_cfg[19]) || (m_st[1] && mode != 1);
            if (blk) resolve = 1;
            else if (!glb_single || m_cfg[20]) begin
               start = 1;
               m_exp_rx = 32'(64'(slave_word) >> (32 - len));
            end else begin
               n_tx = 0; n_st = n_st | 3'b110; if (mode != 2) n_st[0] = 1; resolve = 1;
            end
         end else if (m_try && !m_en) n_try = 0;
         if (cfg_wr) n_cfg = cfg_wdata[22:0];
         if (tx_wr) begin n_tx = tx_wdata; n_st[1] = 0; n_try = 1; end
         if (rx_rd) begin n_st[0] = 0; n_try = 1; end
         if (en_wr) begin
            if (en_wdata && !m_en) begin n_en = 1; n_try = 1; end
            else n_en = en_wdata;
         end
         m_prx = resolve && n_st[0] && mode != 2 && !m_cfg[19];
         m_ptx = resolve && n_st[1] && mode != 1;
         if (start) m_cnt = 2 * len + 1;
         else if (m_cnt > 0) m_cnt--;
         m_cfg = n_cfg; m_st = n_st; m_en = n_en; m_try = n_try; m_tx = n_tx; m_rx = n_rx;
      end
   end

   // ---------------- monitor and slave ----------------
   logic        sclk_prev = 1'b0;
   int          idx = 0, rises = 0, rxf_cnt = 0, txe_cnt = 0;
   logic [63:0] mosi_acc = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic m_txd, m_rxd;
         m_txd = m_en && m_cfg[14] && m_st[1] && (m_cfg[13:12] != 2'd1);
         m_rxd = m_en && m_cfg[15] && m_st[0] && (m_cfg[13:12] != 2'd2);
         chk("R2 cfg", cfg_o, m_cfg);
         chk("R4 status", status_o, m_st);
         chk("R4 tx word", tx_o, m_tx);
         chk("R5 rx word", rx_o, m_rx);
         chk("R3 enable", enable_o, m_en);
         chk("R11 tx dreq", tx_dreq_o, m_txd);
         chk("R11 rx dreq", rx_dreq_o, m_rxd);
         chk("R12 rxf pulse", irq_rxf_o, m_prx);
         chk("R12 txe pulse", irq_txe_o, m_ptx);
         if (irq_rxf_o) rxf_cnt++;
         if (irq_txe_o) txe_cnt++;
      end
      if (sclk_o && !sclk_prev) begin
         rises++; idx++;
         mosi_acc = {mosi_acc[62:0], mosi_o};
      end
      sclk_prev = sclk_o;
      miso = slave_word[31 - (idx % cur_len)];
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog R13 actual=%0d expected=<20000", cyc);
         finish_run();
      end
   end

   // ---------------- drivers ----------------
   task automatic tick(input int n); repeat (n) @(negedge clk); endtask
   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk); cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
   endtask
   task automatic wr_en(input logic v);
      @(negedge clk); en_wr = 1; en_wdata = v; @(negedge clk); en_wr = 0;
   endtask
   task automatic wr_tx(input logic [31:0] v);
      @(negedge clk); tx_wr = 1; tx_wdata = v; @(negedge clk); tx_wr = 0;
   endtask
   task automatic rd_rx();
      @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
   endtask
   task automatic new_word(input logic [31:0] s, input int len);
      slave_word = s; cur_len = len; idx = 0; mosi_acc = '0;
   endtask

   initial begin
      int r0;
      tick(3); rst_n = 1; tick(1);
      // R1 reset state
      chk("R1 cfg", cfg_o, 23'h060000);
      chk("R1 status", status_o, 3'b010);
      chk("R1 enable/tx/rx", {enable_o, tx_o, rx_o}, '0);
      chk("R1 dreqs", {tx_dreq_o, rx_dreq_o}, 2'b00);
      // R2 masking
      wr_cfg(32'hFFFF_FFFF);
      chk("R2 masked cfg", cfg_o, 23'h7FFFFF);
      wr_cfg(32'h0000_C380);
      // R3 disabled channel ignores attempt
      new_word(32'h3C00_0000, 8);
      wr_tx(32'hA5); tick(4);
      chk("R3 disabled status", status_o, 3'b000);
      chk("R3 disabled no sclk", rises, 0);
      wr_en(1); tick(25);
      chk("R4 done status", status_o, 3'b111);
      chk("R4 tx cleared", tx_o, 0);
      chk("R5 rx 8 bits", rx_o, 32'h3C);
      chk("R5 mosi msb first", mosi_acc[7:0], 8'hA5);
      chk("R5 bit count", rises, 8);
      chk("R11 both dreqs", {tx_dreq_o, rx_dreq_o}, 2'b11);
      chk("R12 pulse counts", {rxf_cnt[7:0], txe_cnt[7:0]}, 16'h0101);
      // R8 blocked by full receive word
      wr_tx(32'h11); tick(3);
      chk("R8 blocked status", status_o, 3'b101);
      chk("R8 tx kept", tx_o, 32'h11);
      chk("R12 blocked pulse", {rxf_cnt[7:0], txe_cnt[7:0]}, 16'h0201);
      // R9 read releases the held word
      new_word(32'hC300_0000, 8);
      rd_rx(); tick(25);
      chk("R9 status after read+xfer", status_o, 3'b111);
      chk("R9 rx", rx_o, 32'hC3);
      chk("R9 mosi", mosi_acc[7:0], 8'h11);
      // R8 bypass bit 19
      wr_cfg(32'h0008_C380);
      new_word(32'h5A00_0000, 8);
      wr_tx(32'h22); tick(25);
      chk("R8 bypass rx", rx_o, 32'h5A);
      chk("R8 bypass status", status_o, 3'b111);
      // R6 receive-only
      wr_cfg(32'h0000_D380);
      new_word(32'h8100_0000, 8);
      rd_rx(); tick(25);
      chk("R6 rx-only rx", rx_o, 32'h81);
      chk("R6 rx-only status", status_o, 3'b111);
      chk("R11 rx-only dreqs", {tx_dreq_o, rx_dreq_o}, 2'b01);
      // R7 transmit-only, 32-bit word
      wr_cfg(32'h0000_EF80);
      rd_rx(); tick(3);
      chk("R7 blocked by txe", status_o, 3'b110);
      new_word(32'h1234_5678, 32);
      wr_tx(32'hDEAD_BEEF); tick(80);
      chk("R7 status no rxf", status_o, 3'b110);
      chk("R5 rx 32 bits", rx_o, 32'h1234_5678);
      chk("R5 mosi 32 bits", mosi_acc[31:0], 32'hDEAD_BEEF);
      chk("R11 tx-only dreqs", {tx_dreq_o, rx_dreq_o}, 2'b10);
      // R10 single-channel mode without force bit
      glb_single = 1;
      wr_cfg(32'h0000_C380);
      new_word(32'hFF00_0000, 8);
      r0 = rises;
      wr_tx(32'h77); tick(6);
      chk("R10 status", status_o, 3'b111);
      chk("R10 tx cleared", tx_o, 0);
      chk("R10 rx unchanged", rx_o, 32'h1234_5678);
      chk("R10 no sclk", rises - r0, 0);
      glb_single = 0;
      // R13 attempt held while busy
      wr_cfg(32'h0008_D380);
      new_word(32'h6600_0000, 8);
      r0 = rises;
      wr_tx(32'h99); tick(6);
      wr_tx(32'h44); tick(60);
      chk("R13 two words shifted", rises - r0, 16);
      chk("R13 status", status_o, 3'b111);
      chk("R13 rx", rx_o, 32'h66);
      // R3 plain enable write
      wr_en(0); tick(1);
      chk("R3 disable", enable_o, 1'b0);
      chk("R11 disabled dreqs", {tx_dreq_o, rx_dreq_o}, 2'b00);
      tick(2);
      finish_run();
   end
endmodule